// File: doc/BRIEF.md
# Mixed-Decay PWM Chopper Controller

This block regulates the current in one winding of a bipolar stepper motor by choosing, every system clock, which of the four H-bridge switches are on. It runs a three-phase cycle: it drives current into the coil (charge) until a comparator reports that the set-point has been reached. It then reverses the bridge to return energy to the supply (fast decay) until a second comparator reports that the current has dropped below the decay threshold. After that it lets the coil current recirculate through both low-side switches (slow decay) until the chop period ends, and the cycle starts again.

The chop period is built from an oscillator tick strobe that is synchronous to the system clock. A blanking window keeps comparator glitches that follow each bridge switch from being taken as real events. Every change of switch pattern passes through an all-off cycle. The polarity input chooses which diagonal of the bridge carries the charge current. The enable input shuts the bridge off at once and puts the cycle back at its charge phase.

Top module: `mixed_decay_chopper`

## Requirements
- R1: While reset is high, all four gate outputs are 0 and the mode output reads off (2'b00). Mode codes are: off 2'b00, charge 2'b01, fast 2'b10, slow 2'b11.
- R2: One chop period is PERIOD_TICKS (default 16) oscillator ticks. Slow decay ends only at a period boundary, so in a steady cycle the charge phase begins once per period.
- R3: In charge, an accepted set-point flag moves the cycle to fast decay. The mode output leaves charge one cycle after the edge that accepts the flag.
- R4: In fast decay, an accepted below-threshold flag moves the cycle to slow decay.
- R5: If the set-point flag stays low, charge continues across any number of period boundaries.
- R6: If the below-threshold flag stays low, fast decay continues across any number of period boundaries.
- R7: If the set-point flag is already high when charge begins, the bridge stays in charge for exactly the blanking window plus two cycles, then enters fast decay.
- R8: With polarity high, the gate vector {hs_pos, hs_neg, ls_pos, ls_neg} is 1001 in charge, 0110 in fast decay and 0011 in slow decay.
- R9: With polarity low, the gate vector is 0110 in charge, 1001 in fast decay and 0011 in slow decay.
- R10: Comparator flags are ignored during the BLANK_CYCLES system clocks that follow the application of a new gate pattern.
- R11: When run is low, all gates are 0 at once, without waiting for a clock edge. When run returns high, the cycle restarts in charge.
- R12: A gate vector never changes directly from one non-zero pattern to a different one. Exactly one all-off cycle separates them, and this includes a polarity change in the middle of a phase.
- R13: The default blanking count is 400 ns rounded to the nearest whole system clock. At 125 MHz this gives 50 cycles, so a charge phase entered with the set-point already reached lasts 52 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle strobe per chopper oscillator cycle |
| run | input | 1 | Bridge enable; low forces all gates off |
| fwd | input | 1 | Current polarity: 1 = positive diagonal charges |
| at_setpoint | input | 1 | Comparator: coil current has reached the set-point |
| below_thresh | input | 1 | Comparator: coil current is below the decay threshold |
| hs_pos | output | 1 | High-side switch, positive terminal |
| hs_neg | output | 1 | High-side switch, negative terminal |
| ls_pos | output | 1 | Low-side switch, positive terminal |
| ls_neg | output | 1 | Low-side switch, negative terminal |
| mode | output | 2 | Applied bridge state: 00 off, 01 charge, 10 fast, 11 slow |

## Verification
Two events can land in the same cycle: a chop period boundary and a phase still waiting on its comparator. The bench holds the set-point flag, and later the threshold flag, low for longer than a full period. It then judges that the mode never leaves charge or fast decay at the boundary, and that only the later comparator edge ends the phase. A polarity flip and the blanking window can also coincide. The bench flips polarity while charge is active and checks for exactly one all-off cycle, the new diagonal, and a freshly restarted blanking count, which shows up as a charge length of BLANK_CYCLES+2.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_CHARGE = 2'b01,
        MODE_FAST   = 2'b10,
        MODE_SLOW   = 2'b11
    } bridge_mode_t;

    typedef struct packed {
        logic hs_pos;
        logic hs_neg;
        logic ls_pos;
        logic ls_neg;
    } gate_set_t;

    // Switch pattern for a phase and polarity; off for anything else.
    function automatic gate_set_t gates_for(input bridge_mode_t m, input logic fwd);
        gate_set_t g;
        g = '0;
        case (m)
            MODE_CHARGE: begin
                g.hs_pos = fwd;
                g.ls_neg = fwd;
                g.hs_neg = !fwd;
                g.ls_pos = !fwd;
            end
            MODE_FAST: begin
                g.hs_neg = fwd;
                g.ls_pos = fwd;
                g.hs_pos = !fwd;
                g.ls_neg = !fwd;
            end
            MODE_SLOW: begin
                g.ls_pos = 1'b1;
                g.ls_neg = 1'b1;
            end
            default: g = '0;
        endcase
        return g;
    endfunction

    // Window length in clocks, rounded to nearest.
    function automatic int unsigned blank_default(input int unsigned clk_khz,
                                                  input int unsigned win_ns);
        longint unsigned p;
        p = 64'(clk_khz) * 64'(win_ns);
        return 32'((p + 64'd500000) / 64'd1000000);
    endfunction

endpackage

// File: rtl/chop_period_timer.sv
module chop_period_timer #(
    parameter int unsigned PERIOD_TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic osc_tick,
    output logic period_end
);
    localparam int CW = (PERIOD_TICKS < 2) ? 1 : $clog2(PERIOD_TICKS);
    localparam logic [CW-1:0] LAST = CW'(PERIOD_TICKS - 1);

    logic [CW-1:0] tick_cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tick_cnt <= '0;
        end else if (osc_tick) begin
            tick_cnt <= (tick_cnt == LAST) ? '0 : tick_cnt + 1'b1;
        end
    end

    assign period_end = run && osc_tick && (tick_cnt == LAST);

    // R2: a boundary always restarts the tick count
    a_r2_period_wrap: assert property (@(posedge clk) disable iff (rst)
        period_end |=> (tick_cnt == '0));

endmodule

// File: rtl/chop_phase_fsm.sv
module chop_phase_fsm
    import chop_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         period_end,
    input  logic         cmp_valid,
    input  logic         at_setpoint,
    input  logic         below_thresh,
    output bridge_mode_t phase
);
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= MODE_CHARGE;
        end else begin
            case (phase)
                MODE_CHARGE: if (cmp_valid && at_setpoint)  phase <= MODE_FAST;
                MODE_FAST:   if (cmp_valid && below_thresh) phase <= MODE_SLOW;
                MODE_SLOW:   if (period_end)                phase <= MODE_CHARGE;
                default:                                    phase <= MODE_CHARGE;
            endcase
        end
    end

    // R2: slow decay is left only at a period boundary or on disable
    a_r2_slow_exit: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == MODE_SLOW && phase != MODE_SLOW)
            |-> ($past(period_end) || !$past(run)));

    // R5/R6: charge and fast are never ended by a period boundary alone
    a_r5_no_boundary_exit: assert property (@(posedge clk) disable iff (rst)
        (run && period_end && !cmp_valid && phase != MODE_SLOW)
            |=> $stable(phase));

endmodule

// File: rtl/chop_bridge_drv.sv
module chop_bridge_drv
    import chop_pkg::*;
#(
    parameter int unsigned BLANK_CYCLES = 50
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         fwd,
    input  bridge_mode_t phase,
    output gate_set_t    gates,
    output bridge_mode_t mode_q,
    output logic         cmp_valid
);
    localparam int BW = (BLANK_CYCLES < 1) ? 1 : $clog2(BLANK_CYCLES + 1);
    localparam logic [BW-1:0] BLANK_LOAD = BW'(BLANK_CYCLES);

    gate_set_t      target;
    logic           settled;
    logic [BW-1:0]  blank_q;

    assign target  = gates_for(phase, fwd);
    assign settled = (gates == target) && (mode_q == phase);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            gates   <= '0;
            mode_q  <= MODE_OFF;
            blank_q <= '0;
        end else if (!settled) begin
            if (gates != '0) begin
                gates  <= '0;
                mode_q <= MODE_OFF;
            end else begin
                gates   <= target;
                mode_q  <= phase;
                blank_q <= BLANK_LOAD;
            end
        end else if (blank_q != '0) begin
            blank_q <= blank_q - 1'b1;
        end
    end

    assign cmp_valid = run && settled && (blank_q == '0);

    // R12: a non-zero pattern only ever changes to all-off
    a_r12_break_before_make: assert property (@(posedge clk) disable iff (rst)
        (gates != $past(gates) && $past(gates) != '0) |-> (gates == '0));

    // R10: a freshly applied pattern always blocks the comparators next cycle
    a_r10_blank_after_switch: assert property (@(posedge clk) disable iff (rst)
        ($past(gates) == '0 && gates != '0 && BLANK_CYCLES > 0) |-> !cmp_valid);

endmodule

// File: rtl/mixed_decay_chopper.sv
module mixed_decay_chopper
    import chop_pkg::*;
#(
    parameter int unsigned PERIOD_TICKS = 16,
    parameter int unsigned CLK_KHZ      = 125000,
    parameter int unsigned BLANK_NS     = 400,
    parameter int unsigned BLANK_CYCLES = blank_default(CLK_KHZ, BLANK_NS)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic       run,
    input  logic       fwd,
    input  logic       at_setpoint,
    input  logic       below_thresh,
    output logic       hs_pos,
    output logic       hs_neg,
    output logic       ls_pos,
    output logic       ls_neg,
    output logic [1:0] mode
);
    logic         period_end;
    logic         cmp_valid;
    bridge_mode_t phase;
    bridge_mode_t drv_mode;
    gate_set_t    gates;

    chop_period_timer #(.PERIOD_TICKS(PERIOD_TICKS)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .osc_tick   (osc_tick),
        .period_end (period_end)
    );

    chop_phase_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .run          (run),
        .period_end   (period_end),
        .cmp_valid    (cmp_valid),
        .at_setpoint  (at_setpoint),
        .below_thresh (below_thresh),
        .phase        (phase)
    );

    chop_bridge_drv #(.BLANK_CYCLES(BLANK_CYCLES)) u_drv (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .fwd       (fwd),
        .phase     (phase),
        .gates     (gates),
        .mode_q    (drv_mode),
        .cmp_valid (cmp_valid)
    );

    // Enable gates the switches without waiting for a clock edge.
    assign hs_pos = gates.hs_pos & run;
    assign hs_neg = gates.hs_neg & run;
    assign ls_pos = gates.ls_pos & run;
    assign ls_neg = gates.ls_neg & run;
    assign mode   = run ? drv_mode : MODE_OFF;

    // R10: while comparators are blocked, charge and fast hold their phase
    a_r10_hold_in_blank: assert property (@(posedge clk) disable iff (rst)
        (run && !cmp_valid && phase != MODE_SLOW) |=> (phase == $past(phase)));

    // R11: a disabled cycle returns to charge with the bridge off
    a_r11_idle_restart: assert property (@(posedge clk) disable iff (rst)
        !run |=> (phase == MODE_CHARGE && drv_mode == MODE_OFF));

endmodule

// File: tb/mixed_decay_chopper_test.sv
`timescale 1ns/1ps
module mixed_decay_chopper_test;
    localparam int BLK = 3;
    localparam int TDIV = 4;
    localparam int PER = 16 * TDIV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc_tick = 1'b0;
    logic run = 1'b1, fwd = 1'b1, at_setpoint = 1'b0, below_thresh = 1'b0;
    logic hs_pos, hs_neg, ls_pos, ls_neg;
    logic [1:0] mode;
    logic d_run = 1'b0, d_set = 1'b1;
    logic d_hp, d_hn, d_lp, d_ln;
    logic [1:0] d_mode;

    int n_run = 0, n_fail = 0, cyc = 0;
    bit done = 0, mon_pat = 1;
    logic [3:0] prev_g = 4'b0000;

    always #4 clk = ~clk;

    mixed_decay_chopper #(.BLANK_CYCLES(BLK)) uut (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .run(run), .fwd(fwd),
        .at_setpoint(at_setpoint), .below_thresh(below_thresh),
        .hs_pos(hs_pos), .hs_neg(hs_neg), .ls_pos(ls_pos), .ls_neg(ls_neg), .mode(mode));

    mixed_decay_chopper uut_dflt (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .run(d_run), .fwd(1'b1),
        .at_setpoint(d_set), .below_thresh(1'b0),
        .hs_pos(d_hp), .hs_neg(d_hn), .ls_pos(d_lp), .ls_neg(d_ln), .mode(d_mode));

    wire [3:0] g = {hs_pos, hs_neg, ls_pos, ls_neg};

    function automatic logic [3:0] exp_g(input logic [1:0] m, input logic f);
        case (m)
            2'b01: return f ? 4'b1001 : 4'b0110;
            2'b10: return f ? 4'b0110 : 4'b1001;
            2'b11: return 4'b0011;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #2; cyc++;
    endtask

    task automatic wait_mode(input logic [1:0] m);
        int k = 0;
        while (mode != m && k < 2000) begin step(); k++; end
        check(mode == m, "wait for mode", mode, m);
    endtask

    task automatic count_run(input logic [1:0] m, output int n);
        n = 0;
        while (mode == m && n < 5000) begin n++; step(); end
    endtask

    // oscillator strobe, one per TDIV clocks
    initial begin
        int div = 0;
        forever begin
            @(posedge clk); #1;
            osc_tick = (div == TDIV - 1);
            div = (div + 1) % TDIV;
        end
    end

    // pattern (R8/R9) and break-before-make (R12) monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (mon_pat && mode != 2'b00)
                check(g == exp_g(mode, fwd), "R8/R9 pattern", g, exp_g(mode, fwd));
            if (prev_g != 4'b0000 && g != 4'b0000 && g != prev_g)
                check(1'b0, "R12 direct pattern change", g, 0);
            prev_g = g;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int n, t0, t1;
        bit ok;
        // R1 reset state
        repeat (3) step();
        check(g == 4'b0000, "R1 gates in reset", g, 0);
        check(mode == 2'b00, "R1 mode in reset", mode, 0);
        rst = 1'b0;
        step();
        check(mode == 2'b01 && g == 4'b1001, "R8 first charge", g, 9);

        // R10 pulse inside blanking is ignored
        at_setpoint = 1'b1; step(); at_setpoint = 1'b0;
        ok = 1;
        for (int i = 0; i < 10; i++) begin step(); if (mode != 2'b01) ok = 0; end
        check(ok, "R10 blanked pulse ignored", mode, 1);

        // R5 charge stretches over period boundaries
        ok = 1;
        for (int i = 0; i < 2 * PER; i++) begin step(); if (mode != 2'b01) ok = 0; end
        check(ok, "R5 charge persists", mode, 1);

        // R3 set-point ends charge
        at_setpoint = 1'b1;
        count_run(2'b01, n); check(n == 2, "R3 charge exit latency", n, 2);
        count_run(2'b00, n); check(n == 1, "R12 dead cycle", n, 1);
        check(mode == 2'b10 && g == 4'b0110, "R8 fast pattern", g, 6);

        // R6 fast stretches over period boundaries
        ok = 1;
        for (int i = 0; i < 2 * PER; i++) begin step(); if (mode != 2'b10) ok = 0; end
        check(ok, "R6 fast persists", mode, 2);

        // R4 threshold ends fast
        below_thresh = 1'b1;
        count_run(2'b10, n); check(n == 2, "R4 fast exit latency", n, 2);
        count_run(2'b00, n); check(n == 1, "R12 dead cycle", n, 1);
        if (mode == 2'b11) check(g == 4'b0011, "R8 slow pattern", g, 3);

        // R7 / R2 steady cycle with both flags already high
        wait_mode(2'b11);
        wait_mode(2'b01); t0 = cyc;
        count_run(2'b01, n); check(n == BLK + 2, "R7 short charge", n, BLK + 2);
        count_run(2'b00, n); check(n == 1, "R12 dead cycle", n, 1);
        count_run(2'b10, n); check(n == BLK + 2, "R7 short fast", n, BLK + 2);
        check(mode == 2'b00, "R12 dead before slow", mode, 0);
        wait_mode(2'b11); check(g == 4'b0011, "R8 slow pattern", g, 3);
        wait_mode(2'b01); t1 = cyc;
        check(t1 - t0 == PER, "R2 period length", t1 - t0, PER);
        wait_mode(2'b11);
        wait_mode(2'b01); t0 = cyc;
        check(t0 - t1 == PER, "R2 period length", t0 - t1, PER);

        // R9 negative polarity
        wait_mode(2'b11); fwd = 1'b0;
        wait_mode(2'b01); check(g == 4'b0110, "R9 charge pattern", g, 6);
        wait_mode(2'b10); check(g == 4'b1001, "R9 fast pattern", g, 9);
        wait_mode(2'b11); check(g == 4'b0011, "R9 slow pattern", g, 3);

        // R12 polarity flip mid-charge
        at_setpoint = 1'b0;
        wait_mode(2'b01);
        repeat (3) step();
        mon_pat = 0; fwd = 1'b1;
        step(); check(g == 4'b0000 && mode == 2'b00, "R12 flip goes off", g, 0);
        step(); check(g == 4'b1001 && mode == 2'b01, "R12 flip new diagonal", g, 9);
        mon_pat = 1; at_setpoint = 1'b1;
        count_run(2'b01, n); check(n == BLK + 2, "R10 blank restarts after flip", n, BLK + 2);

        // R11 disable
        wait_mode(2'b10);
        at_setpoint = 1'b0;
        @(negedge clk); run = 1'b0; #1;
        check(g == 4'b0000, "R11 gates off immediately", g, 0);
        check(mode == 2'b00, "R11 mode off", mode, 0);
        step(); step();
        check(g == 4'b0000, "R11 gates stay off", g, 0);
        run = 1'b1; step();
        check(mode == 2'b01 && g == 4'b1001, "R11 restart in charge", g, 9);

        // R13 default blanking (52 cycles at 125 MHz)
        d_run = 1'b1; step();
        n = 0;
        while (d_mode == 2'b01 && n < 500) begin n++; step(); end
        check(n == 52, "R13 default blank charge length", n, 52);
        check(d_mode == 2'b00, "R13 dead after charge", d_mode, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule